// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach PHY management registers over a two-wire management bus. Software fills a small word-addressed register set: an address word used by extended-addressing frames, a write-data word, and a command word. Writing the command word with its go bit set launches one serial frame. The go bit reads back as set while the frame is on the wire and drops by itself when the last bit has been clocked, after which the next command may be issued.

The frame type and operation fields of the command are copied straight into the serial frame. One frame type gives classic direct-access frames (write and read). The other gives indirect-access frames in which an address frame first loads the PHY's address pointer, and later data-write, read or read-with-post-increment frames act on it. On read frames the master releases the line during turnaround, checks that the PHY pulls it low, captures sixteen data bits and records success or failure in a status bit.

The bus clock is divided down from the system clock by a parameter. The master changes its data output just after the falling bus clock edge and samples the returned data at the rising edge.

Top module: `mdio_master`

## Requirements
- R1: After reset the bus clock output is low, the output enable is low, the data output is high, and every register reads as zero.
- R2: Registers sit at byte offsets 0x00 (command), 0x04 (address word, bits 15:0), 0x08 (write data, bits 15:0), 0x0C (read data, bits 15:0) and 0x10 (status, bit 0). The command holds the device/register address in bits 4:0, the port address in bits 9:5, the operation in bits 11:10, the frame type in bits 13:12 and the go bit at bit 14; bits 13:0 read back as written.
- R3: A command write with bit 14 set while idle starts a frame; bit 14 then reads 1 until the frame ends and afterwards reads 0 by itself.
- R4: Each frame is 64 bus clocks long and starts with 32 one bits, then frame type (2 bits), operation (2 bits), port address (5 bits) and device/register address (5 bits), most significant bit first, copied unchanged from the command.
- R5: Frames that are not reads carry turnaround bits 1 then 0, then 16 data bits MSB first: the address word when frame type is 0 and operation is 0, otherwise the write-data word.
- R6: Read frames (frame type 1 with operation 2, or frame type 0 with operation 2 or 3) release the line (output enable low) from the first turnaround bit to the end, and on success place the 16 sampled bits, first received as MSB, in the read-data register.
- R7: If the line is not low at the second turnaround bit of a read, status bit 0 becomes 1 and read data keeps its old value; a successful read sets it to 0; frames that are not reads leave it unchanged.
- R8: The bus clock has a period of DIV system clocks (default 50) while a frame runs and stays low while idle.
- R9: Command writes made while a frame is running are ignored: the fields keep their values, the running frame is unaltered and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
A table of frames covers direct writes and reads, an indirect address frame, an indirect data write and both indirect read operations, each with distinct port, device and data patterns so that a field placed in the wrong slot or a data source picked wrongly shows up in the captured frame. A read with no responding PHY tells success from failure and shows that read data is kept, a write after it shows that status is left alone, and a later good read shows that status clears. A directed case writes a new command mid-frame to separate a guarded command register from an unguarded one, and measures the bus clock period during the same frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ST_W  = 2;
  localparam int OP_W  = 2;
  localparam int PA_W  = 5;
  localparam int DA_W  = 5;
  localparam int DAT_W = 16;
  localparam int HDR_W = ST_W + OP_W + PA_W + DA_W;
  localparam int OFS_W = 5;
  localparam int BUS_W = 32;
  localparam int GO_BIT = HDR_W;

  localparam logic [OFS_W-1:0] OFS_CMD = 5'h00;
  localparam logic [OFS_W-1:0] OFS_ADR = 5'h04;
  localparam logic [OFS_W-1:0] OFS_WDT = 5'h08;
  localparam logic [OFS_W-1:0] OFS_RDT = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_STS = 5'h10;

  localparam logic [ST_W-1:0] FT_IND = 2'd0;
  localparam logic [ST_W-1:0] FT_DIR = 2'd1;
  localparam logic [OP_W-1:0] OPC_DIR_RD = 2'd2;
  localparam logic [OP_W-1:0] OPC_IND_AD = 2'd0;

  typedef struct packed {
    logic [ST_W-1:0] ft;
    logic [OP_W-1:0] opc;
    logic [PA_W-1:0] pa;
    logic [DA_W-1:0] da;
  } cmd_t;

  function automatic logic cmd_is_read(cmd_t c);
    return ((c.ft == FT_DIR) && (c.opc == OPC_DIR_RD)) ||
           ((c.ft == FT_IND) && c.opc[1]);
  endfunction

  function automatic logic cmd_sends_addr(cmd_t c);
    return (c.ft == FT_IND) && (c.opc == OPC_IND_AD);
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  assign rise_tick = en && (cnt_q == RISE_AT);
  assign fall_tick = en && (cnt_q == FALL_AT);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      if (fall_tick) cnt_d = '0;
      else           cnt_d = cnt_q + 1'b1;
      if (rise_tick)      mdc_d = 1'b1;
      else if (fall_tick) mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R8
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  // R8
  mdc_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_tick));

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  cmd_t             go_cmd,
  input  logic [DAT_W-1:0] go_data,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             done,
  output logic             done_rd,
  output logic             rd_fail,
  output logic [DAT_W-1:0] rd_data
);
  localparam int FL = PRE_LEN + HDR_W + 2 + DAT_W;
  localparam int CW = $clog2(FL);
  localparam logic [CW-1:0] TA1  = CW'(PRE_LEN + HDR_W);
  localparam logic [CW-1:0] TA2  = CW'(PRE_LEN + HDR_W + 1);
  localparam logic [CW-1:0] D0   = CW'(PRE_LEN + HDR_W + 2);
  localparam logic [CW-1:0] LAST = CW'(FL - 1);

  logic             busy_q, busy_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [FL-1:0]    sh_q, sh_d;
  logic             oe_q, oe_d;
  logic             rd_q, rd_d;
  logic             fail_q, fail_d;
  logic [DAT_W-1:0] rx_q, rx_d;
  logic [CW-1:0]    cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign done    = busy_q && fall_tick && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    oe_d   = oe_q;
    rd_d   = rd_q;
    fail_d = fail_q;
    rx_d   = rx_q;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sh_d   = {{PRE_LEN{1'b1}}, go_cmd, 2'b10, go_data};
      oe_d   = 1'b1;
      rd_d   = cmd_is_read(go_cmd);
      fail_d = 1'b0;
    end else if (busy_q) begin
      if (rise_tick && rd_q) begin
        if (cnt_q == TA2) fail_d = mdio_i;
        if (cnt_q >= D0)  rx_d = {rx_q[DAT_W-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          sh_d   = '1;
        end else begin
          cnt_d = cnt_inc;
          sh_d  = {sh_q[FL-2:0], 1'b1};
          oe_d  = !(rd_q && (cnt_inc >= TA1));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '1;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      fail_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      oe_q   <= oe_d;
      rd_q   <= rd_d;
      fail_q <= fail_d;
      rx_q   <= rx_d;
    end
  end

  assign mdio_o  = sh_q[FL-1];
  assign mdio_oe = oe_q;
  assign busy    = busy_q;
  assign done_rd = rd_q;
  assign rd_fail = fail_q;
  assign rd_data = rx_q;

  // R3
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);

  // R3
  end_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R4
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_tick) |=> $stable(mdio_o));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             done_rd,
  input  logic             rd_fail,
  input  logic [DAT_W-1:0] rd_data,
  output logic             go,
  output cmd_t             go_cmd,
  output logic [DAT_W-1:0] go_data
);
  cmd_t             cmd_q, cmd_d;
  logic [DAT_W-1:0] adr_q, adr_d;
  logic [DAT_W-1:0] wdt_q, wdt_d;
  logic [DAT_W-1:0] rdt_q, rdt_d;
  logic             sts_q, sts_d;
  logic             cmd_hit, cmd_take;

  assign cmd_hit  = bus_we && (bus_addr == OFS_CMD);
  assign cmd_take = cmd_hit && !busy;
  assign go       = cmd_take && bus_wdata[GO_BIT];
  assign go_cmd   = cmd_t'(bus_wdata[HDR_W-1:0]);
  assign go_data  = cmd_sends_addr(go_cmd) ? adr_q : wdt_q;

  always_comb begin
    cmd_d = cmd_q;
    adr_d = adr_q;
    wdt_d = wdt_q;
    rdt_d = rdt_q;
    sts_d = sts_q;
    if (cmd_take) cmd_d = go_cmd;
    if (bus_we && (bus_addr == OFS_ADR)) adr_d = bus_wdata[DAT_W-1:0];
    if (bus_we && (bus_addr == OFS_WDT)) wdt_d = bus_wdata[DAT_W-1:0];
    if (done && done_rd) begin
      sts_d = rd_fail;
      if (!rd_fail) rdt_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      adr_q <= '0;
      wdt_q <= '0;
      rdt_q <= '0;
      sts_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      adr_q <= adr_d;
      wdt_q <= wdt_d;
      rdt_q <= rdt_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CMD: bus_rdata = {{(BUS_W-HDR_W-1){1'b0}}, busy, cmd_q};
      OFS_ADR: bus_rdata = {{(BUS_W-DAT_W){1'b0}}, adr_q};
      OFS_WDT: bus_rdata = {{(BUS_W-DAT_W){1'b0}}, wdt_q};
      OFS_RDT: bus_rdata = {{(BUS_W-DAT_W){1'b0}}, rdt_q};
      OFS_STS: bus_rdata = {{(BUS_W-1){1'b0}}, sts_q};
      default: bus_rdata = '0;
    endcase
  end

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_hit) |=> $stable(cmd_q));

  // R7
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && done_rd) |=> $stable(sts_q));

  // R7
  rdt_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_rd && rd_fail) |=> $stable(rdt_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV     = 50,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             go, busy, done, done_rd, rd_fail;
  cmd_t             go_cmd;
  logic [DAT_W-1:0] go_data, rd_data;
  logic             rise_tick, fall_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .done_rd   (done_rd),
    .rd_fail   (rd_fail),
    .rd_data   (rd_data),
    .go        (go),
    .go_cmd    (go_cmd),
    .go_data   (go_data)
  );

  mdio_clkdiv #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go        (go),
    .go_cmd    (go_cmd),
    .go_data   (go_data),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .done      (done),
    .done_rd   (done_rd),
    .rd_fail   (rd_fail),
    .rd_data   (rd_data)
  );

endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

  typedef struct packed {
    logic [1:0]  ft;
    logic [1:0]  opc;
    logic [4:0]  pa;
    logic [4:0]  da;
    logic [15:0] adr;
    logic [15:0] wdt;
    logic        phy_on;
    logic [15:0] rsp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd1, 5'h03, 5'h11, 16'h0000, 16'hA5C3, 1'b1, 16'h0000},
    '{2'd1, 2'd2, 5'h1F, 5'h00, 16'h0000, 16'h0000, 1'b1, 16'h1234},
    '{2'd0, 2'd0, 5'h0A, 5'h07, 16'hBEEF, 16'h0000, 1'b1, 16'h0000},
    '{2'd0, 2'd1, 5'h0A, 5'h07, 16'hBEEF, 16'h5A5A, 1'b1, 16'h0000},
    '{2'd0, 2'd3, 5'h15, 5'h1E, 16'h0000, 16'h0000, 1'b1, 16'hF00D},
    '{2'd1, 2'd2, 5'h00, 5'h1F, 16'h0000, 16'h0000, 1'b0, 16'hDEAD},
    '{2'd1, 2'd1, 5'h12, 5'h09, 16'h7777, 16'h0F0F, 1'b1, 16'h0000},
    '{2'd0, 2'd2, 5'h01, 5'h02, 16'h0000, 16'h0000, 1'b1, 16'h8001}
  };

  logic        clk, rst_n, bus_we, mdc, mdio_o, mdio_oe, mdio_i;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int          nchk, nfail, idx;
  logic [63:0] cap;
  logic        phy_on;
  logic [15:0] rsp;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // PHY responder: counts rising bus clock edges since the command was issued
  always @(posedge mdc) begin
    if (idx < 64) cap[63-idx] = mdio_o;
    idx = idx + 1;
  end

  assign mdio_i = mdio_oe ? mdio_o :
                  (phy_on && idx == 47) ? 1'b0 :
                  (phy_on && idx >= 48 && idx <= 63) ? rsp[63-idx] : 1'b1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output logic ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      rd(5'h00, d);
      if (!d[14]) begin ok = 1'b1; break; end
      repeat (10) @(negedge clk);
    end
  endtask

  function automatic logic is_rd(vec_t v);
    return (v.ft == 2'd1 && v.opc == 2'd2) || (v.ft == 2'd0 && v.opc[1]);
  endfunction

  initial begin
    logic [31:0] d;
    logic        ok, exp_sts;
    logic [15:0] exp_rdt, exp_dat;
    logic [45:0] exp_hdr;
    real         t0, t1;
    nchk = 0; nfail = 0; idx = 99; cap = '0;
    phy_on = 1'b1; rsp = '0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!mdc && !mdio_oe && mdio_o, "R1 pins", {61'b0, mdc, mdio_oe, mdio_o}, 64'h1);
    for (int a = 0; a <= 16; a += 4) begin
      rd(a[4:0], d);
      chk(d == 32'h0, "R1 register", {32'b0, d}, 64'h0);
    end

    exp_sts = 1'b0; exp_rdt = 16'h0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      wr(5'h04, {16'h0, v.adr});
      wr(5'h08, {16'h0, v.wdt});
      rd(5'h04, d);
      chk(d[15:0] == v.adr, "R2 address word", {32'b0, d}, {48'b0, v.adr});
      phy_on = v.phy_on; rsp = v.rsp; idx = 0;
      wr(5'h00, {17'h0, 1'b1, v.ft, v.opc, v.pa, v.da});
      rd(5'h00, d);
      chk(d[14] == 1'b1, "R3 go reads 1 while running", {32'b0, d}, 64'h4000);
      chk(d[13:0] == {v.ft, v.opc, v.pa, v.da}, "R2 command fields",
          {32'b0, d}, {50'b0, v.ft, v.opc, v.pa, v.da});
      wait_idle(ok);
      chk(ok, "R3 go clears at frame end", {63'b0, ok}, 64'h1);
      chk(!mdc && !mdio_oe, "R8 idle bus clock low", {62'b0, mdc, mdio_oe}, 64'h0);
      exp_hdr = {32'hFFFF_FFFF, v.ft, v.opc, v.pa, v.da};
      chk(cap[63:18] == exp_hdr, "R4 frame header", {18'b0, cap[63:18]}, {18'b0, exp_hdr});
      if (!is_rd(v)) begin
        exp_dat = (v.ft == 2'd0 && v.opc == 2'd0) ? v.adr : v.wdt;
        chk(cap[17:0] == {2'b10, exp_dat}, "R5 turnaround and data",
            {46'b0, cap[17:0]}, {46'b0, 2'b10, exp_dat});
      end else begin
        exp_sts = !v.phy_on;
        if (v.phy_on) exp_rdt = v.rsp;
        rd(5'h0C, d);
        chk(d[15:0] == exp_rdt, "R6 read data", {32'b0, d}, {48'b0, exp_rdt});
      end
      rd(5'h10, d);
      chk(d[0] == exp_sts, "R7 status", {32'b0, d}, {63'b0, exp_sts});
    end

    // R9 command write during a running frame, R8 bus clock period
    phy_on = 1'b1; rsp = 16'hCAFE; idx = 0;
    wr(5'h00, {17'h0, 1'b1, 2'd1, 2'd2, 5'h02, 5'h03});
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk((t1 - t0) == 1000.0, "R8 bus clock period", 64'(int'((t1 - t0) / 20.0)), 64'd50);
    wr(5'h00, {17'h0, 1'b1, 2'd0, 2'd1, 5'h1F, 5'h1F});
    rd(5'h00, d);
    chk(d[13:0] == {2'd1, 2'd2, 5'h02, 5'h03}, "R9 fields kept", {32'b0, d},
        {50'b0, 2'd1, 2'd2, 5'h02, 5'h03});
    wait_idle(ok);
    chk(ok, "R3 go clears after guarded frame", {63'b0, ok}, 64'h1);
    exp_hdr = {32'hFFFF_FFFF, 2'd1, 2'd2, 5'h02, 5'h03};
    chk(cap[63:18] == exp_hdr, "R9 running frame unaltered", {18'b0, cap[63:18]}, {18'b0, exp_hdr});
    rd(5'h0C, d);
    chk(d[15:0] == 16'hCAFE, "R6 read data after guarded frame", {32'b0, d}, 64'hCAFE);
    repeat (300) @(negedge clk);
    rd(5'h00, d);
    chk(!d[14] && !mdc && idx == 64, "R9 no second frame", {31'b0, d[14], mdc, 31'(idx)}, 64'd64);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule